// File: doc/BRIEF.md
# Interrupt Destination Match Unit

This block decides, for one interrupt agent, whether that agent takes an inter-processor interrupt message. A message carries the sender's identifier, a two-bit shorthand, a mode bit that picks physical or logical addressing, and an 8-bit destination. The agent supplies its own physical identifier and its own logical identifier. A shorthand, when present, replaces all addressing: self only, everyone, or everyone but the sender.

Logical addressing has two formats. In flat format the logical identifier is a bitmask, and any shared bit with the destination is a hit. In cluster format the upper nibble names a cluster (0 to 14, with 15 meaning every cluster) and the lower nibble is a mask of up to four members. The format is held in a register that resets to flat. That register can be rewritten only while the agent is software-disabled. The decision comes out on a registered `accept` pulse, one cycle after each valid message.

Top module: `ipi_dest_match`

## Requirements
- R1: After reset `accept` is 0 and `fmt_cluster` is 0, which means flat logical format.
- R2: Shorthand code 2'b01 (self) accepts exactly when `msg_src_id` equals `own_phys_id`.
- R3: Shorthand code 2'b10 (all including sender) always accepts.
- R4: Shorthand code 2'b11 (all excluding sender) accepts exactly when `msg_src_id` differs from `own_phys_id`.
- R5: With any shorthand other than 2'b00, the values of `msg_logical` and `msg_dest` have no effect on `accept`.
- R6: Shorthand 2'b00 with `msg_logical`=0 (physical) accepts when `msg_dest` equals `own_phys_id` or is 8'hFF.
- R7: Shorthand 2'b00 with `msg_logical`=1 in flat format accepts when `msg_dest & own_logical_id` is non-zero.
- R8: Shorthand 2'b00 with `msg_logical`=1 in cluster format accepts when `msg_dest[7:4]` equals `own_logical_id[7:4]` or is 4'hF, and `msg_dest[3:0] & own_logical_id[3:0]` is non-zero.
- R9: When `fmt_wr` is high while `sw_enable` is 0, `fmt_cluster` takes the value of `fmt_wdata` (1 = cluster, 0 = flat) on the next cycle. When `fmt_wr` is high while `sw_enable` is 1, the write is ignored.
- R10: `accept` is registered. It is high in the cycle after a cycle with `msg_valid` high and a match, for exactly one cycle per valid cycle, and it is never high without `msg_valid` in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_enable | input | 1 | Agent software-enabled; blocks format writes |
| fmt_wr | input | 1 | Format register write strobe |
| fmt_wdata | input | 1 | Format value to write: 1 cluster, 0 flat |
| fmt_cluster | output | 1 | Current format: 1 cluster, 0 flat |
| msg_valid | input | 1 | Message present this cycle |
| msg_src_id | input | 8 | Physical identifier of the sender |
| msg_shorthand | input | 2 | 00 none, 01 self, 10 all incl., 11 all excl. |
| msg_logical | input | 1 | 0 physical addressing, 1 logical addressing |
| msg_dest | input | 8 | Destination field |
| own_phys_id | input | 8 | This agent's physical identifier |
| own_logical_id | input | 8 | This agent's logical identifier (cluster/member in cluster format) |
| accept | output | 1 | Agent accepts the message, one cycle after `msg_valid` |

## Verification
Both results take one register stage. `accept` reflects the message that was on the inputs at the previous rising edge, and a format write shows on `fmt_cluster` after the edge that captures it. The bench changes its inputs on the falling edge and reads results on the following falling edge, so it samples after exactly one rising edge. After each message it drops `msg_valid` and checks again one cycle later, which confirms the pulse lasts a single cycle.

// File: rtl/ipi_dm_pkg.sv
package ipi_dm_pkg;

    typedef enum logic [1:0] {
        SH_NONE     = 2'b00,
        SH_SELF     = 2'b01,
        SH_ALL_INCL = 2'b10,
        SH_ALL_EXCL = 2'b11
    } shorthand_e;

    typedef enum logic {
        FMT_FLAT    = 1'b0,
        FMT_CLUSTER = 1'b1
    } fmt_e;

endpackage

// File: rtl/ipi_dm_fmt_reg.sv
module ipi_dm_fmt_reg
    import ipi_dm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sw_enable,
    input  logic wr_en,
    input  logic wr_cluster,
    output fmt_e fmt_q
);

    typedef struct packed {
        fmt_e fmt;
    } fmt_state_t;

    fmt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en && !sw_enable) begin
            st_d.fmt = wr_cluster ? FMT_CLUSTER : FMT_FLAT;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.fmt <= FMT_FLAT;
        end else begin
            st_q <= st_d;
        end
    end

    assign fmt_q = st_q.fmt;

    // A write while the agent is enabled leaves the format untouched
    assert_locked_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sw_enable) |=> (fmt_q == $past(fmt_q)));

    // A write while disabled lands on the next cycle
    assert_open_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !sw_enable) |=> (fmt_q == ($past(wr_cluster) ? FMT_CLUSTER : FMT_FLAT)));

endmodule

// File: rtl/ipi_dm_phys_match.sv
module ipi_dm_phys_match #(
    parameter int ID_W = 8
) (
    input  logic [ID_W-1:0] dest,
    input  logic [ID_W-1:0] own_id,
    output logic            hit
);

    localparam logic [ID_W-1:0] BCAST = {ID_W{1'b1}};

    logic exact;
    logic bcast;

    always_comb begin
        exact = (dest == own_id);
        bcast = (dest == BCAST);
        hit   = exact || bcast;
    end

endmodule

// File: rtl/ipi_dm_logic_match.sv
module ipi_dm_logic_match
    import ipi_dm_pkg::*;
#(
    parameter int ID_W      = 8,
    parameter int CLUSTER_W = 4
) (
    input  fmt_e            fmt,
    input  logic [ID_W-1:0] dest,
    input  logic [ID_W-1:0] own_logical,
    output logic            hit
);

    localparam int MEMBER_W = ID_W - CLUSTER_W;
    localparam logic [CLUSTER_W-1:0] ALL_CLUSTERS = {CLUSTER_W{1'b1}};

    logic [ID_W-1:0]      flat_overlap;
    logic [MEMBER_W-1:0]  member_overlap;
    logic                 flat_hit;
    logic                 cluster_sel;
    logic                 cluster_hit;

    // per-bit overlap of the destination mask with this agent's mask
    for (genvar b = 0; b < ID_W; b++) begin : g_flat
        assign flat_overlap[b] = dest[b] & own_logical[b];
    end

    for (genvar m = 0; m < MEMBER_W; m++) begin : g_member
        assign member_overlap[m] = dest[m] & own_logical[m];
    end

    always_comb begin
        flat_hit    = |flat_overlap;
        cluster_sel = (dest[ID_W-1 -: CLUSTER_W] == own_logical[ID_W-1 -: CLUSTER_W])
                   || (dest[ID_W-1 -: CLUSTER_W] == ALL_CLUSTERS);
        cluster_hit = cluster_sel && (|member_overlap);
        hit         = (fmt == FMT_CLUSTER) ? cluster_hit : flat_hit;
    end

endmodule

// File: rtl/ipi_dest_match.sv
module ipi_dest_match
    import ipi_dm_pkg::*;
#(
    parameter int ID_W      = 8,
    parameter int CLUSTER_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sw_enable,
    input  logic            fmt_wr,
    input  logic            fmt_wdata,
    output logic            fmt_cluster,
    input  logic            msg_valid,
    input  logic [ID_W-1:0] msg_src_id,
    input  logic [1:0]      msg_shorthand,
    input  logic            msg_logical,
    input  logic [ID_W-1:0] msg_dest,
    input  logic [ID_W-1:0] own_phys_id,
    input  logic [ID_W-1:0] own_logical_id,
    output logic            accept
);

    localparam logic [ID_W-1:0] PHYS_BCAST = {ID_W{1'b1}};

    typedef struct packed {
        logic accept;
    } acc_state_t;

    fmt_e       fmt_q;
    logic       phys_hit;
    logic       logic_hit;
    logic       is_sender;
    logic       match;
    shorthand_e sh;
    acc_state_t st_d, st_q;

    ipi_dm_fmt_reg i_fmt_reg (
        .clk        (clk),
        .rst_n      (rst_n),
        .sw_enable  (sw_enable),
        .wr_en      (fmt_wr),
        .wr_cluster (fmt_wdata),
        .fmt_q      (fmt_q)
    );

    ipi_dm_phys_match #(.ID_W(ID_W)) i_phys (
        .dest   (msg_dest),
        .own_id (own_phys_id),
        .hit    (phys_hit)
    );

    ipi_dm_logic_match #(.ID_W(ID_W), .CLUSTER_W(CLUSTER_W)) i_logic (
        .fmt         (fmt_q),
        .dest        (msg_dest),
        .own_logical (own_logical_id),
        .hit         (logic_hit)
    );

    always_comb begin
        sh        = shorthand_e'(msg_shorthand);
        is_sender = (msg_src_id == own_phys_id);
        unique case (sh)
            SH_SELF:     match = is_sender;
            SH_ALL_INCL: match = 1'b1;
            SH_ALL_EXCL: match = !is_sender;
            default:     match = msg_logical ? logic_hit : phys_hit;
        endcase
        st_d.accept = msg_valid && match;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.accept <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign accept      = st_q.accept;
    assign fmt_cluster = (fmt_q == FMT_CLUSTER);

    assert_no_spurious_R10: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> $past(msg_valid));

    assert_self_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_shorthand == 2'b01 && msg_src_id != own_phys_id) |=> !accept);

    assert_all_incl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_shorthand == 2'b10) |=> accept);

    assert_all_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_shorthand == 2'b11) |=> (accept == ($past(msg_src_id) != $past(own_phys_id))));

    assert_phys_bcast_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_shorthand == 2'b00 && !msg_logical && msg_dest == PHYS_BCAST) |=> accept);

    assert_empty_logical_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_shorthand == 2'b00 && msg_logical && msg_dest == '0) |=> !accept);

endmodule

// File: tb/test_ipi_dest_match.sv
`timescale 1ns/1ps
module test_ipi_dest_match;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sw_enable = 1'b0;
    logic       fmt_wr = 1'b0;
    logic       fmt_wdata = 1'b0;
    logic       fmt_cluster;
    logic       msg_valid = 1'b0;
    logic [7:0] msg_src_id = 8'h00;
    logic [1:0] msg_shorthand = 2'b00;
    logic       msg_logical = 1'b0;
    logic [7:0] msg_dest = 8'h00;
    logic [7:0] own_phys_id = 8'h23;
    logic [7:0] own_logical_id = 8'h35;
    logic       accept;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    ipi_dest_match i_ipi_dest_match (
        .clk(clk), .rst_n(rst_n), .sw_enable(sw_enable), .fmt_wr(fmt_wr),
        .fmt_wdata(fmt_wdata), .fmt_cluster(fmt_cluster), .msg_valid(msg_valid),
        .msg_src_id(msg_src_id), .msg_shorthand(msg_shorthand), .msg_logical(msg_logical),
        .msg_dest(msg_dest), .own_phys_id(own_phys_id), .own_logical_id(own_logical_id),
        .accept(accept)
    );

    task automatic check(input string req, input string what, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s %s: got %b expected %b", req, what, got, exp);
        end
    endtask

    // one message, then check the pulse and its end
    task automatic send(input string req, input logic [7:0] src, input logic [1:0] sh,
                        input logic lg, input logic [7:0] dst, input logic exp);
        @(negedge clk);
        msg_valid = 1'b1; msg_src_id = src; msg_shorthand = sh;
        msg_logical = lg; msg_dest = dst;
        @(negedge clk);
        check(req, $sformatf("accept sh=%b lg=%b dst=%h src=%h", sh, lg, dst, src), accept, exp);
        msg_valid = 1'b0;
        @(negedge clk);
        check("R10", "accept drops after message", accept, 1'b0);
    endtask

    task automatic write_fmt(input logic en, input logic val);
        @(negedge clk);
        sw_enable = en; fmt_wr = 1'b1; fmt_wdata = val;
        @(negedge clk);
        fmt_wr = 1'b0;
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        check("R1", "accept in reset", accept, 1'b0);
        check("R1", "format in reset", fmt_cluster, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "accept after reset", accept, 1'b0);
        check("R1", "format after reset is flat", fmt_cluster, 1'b0);
    endtask

    task automatic t_shorthand;
        send("R2", 8'h23, 2'b01, 1'b0, 8'h00, 1'b1);
        send("R2", 8'h10, 2'b01, 1'b0, 8'h23, 1'b0);
        send("R3", 8'h23, 2'b10, 1'b0, 8'h00, 1'b1);
        send("R3", 8'h10, 2'b10, 1'b1, 8'h00, 1'b1);
        send("R4", 8'h23, 2'b11, 1'b0, 8'hFF, 1'b0);
        send("R4", 8'h10, 2'b11, 1'b1, 8'h00, 1'b1);
    endtask

    task automatic t_ignore_fields;
        // these fields alone would reject / accept; shorthand decides
        send("R5", 8'h10, 2'b10, 1'b1, 8'h00, 1'b1);
        send("R5", 8'h10, 2'b01, 1'b0, 8'hFF, 1'b0);
        send("R5", 8'h23, 2'b11, 1'b0, 8'h23, 1'b0);
    endtask

    task automatic t_physical;
        send("R6", 8'h10, 2'b00, 1'b0, 8'h23, 1'b1);
        send("R6", 8'h10, 2'b00, 1'b0, 8'h24, 1'b0);
        send("R6", 8'h10, 2'b00, 1'b0, 8'hFF, 1'b1);
    endtask

    task automatic t_flat;
        send("R7", 8'h10, 2'b00, 1'b1, 8'h01, 1'b1);
        send("R7", 8'h10, 2'b00, 1'b1, 8'hCA, 1'b0);
        send("R7", 8'h10, 2'b00, 1'b1, 8'h20, 1'b1);
        send("R7", 8'h10, 2'b00, 1'b1, 8'h00, 1'b0);
    endtask

    task automatic t_format_lock;
        write_fmt(1'b1, 1'b1);
        check("R9", "write while enabled ignored", fmt_cluster, 1'b0);
        // still flat: 0x31 & 0x35 nonzero in flat, cluster would also hit; use 0x41
        send("R9", 8'h10, 2'b00, 1'b1, 8'h41, 1'b1);
        write_fmt(1'b0, 1'b1);
        check("R9", "write while disabled taken", fmt_cluster, 1'b1);
    endtask

    task automatic t_cluster;
        send("R8", 8'h10, 2'b00, 1'b1, 8'h31, 1'b1);
        send("R8", 8'h10, 2'b00, 1'b1, 8'h32, 1'b0);
        send("R8", 8'h10, 2'b00, 1'b1, 8'h41, 1'b0);
        send("R8", 8'h10, 2'b00, 1'b1, 8'hF4, 1'b1);
        send("R8", 8'h10, 2'b00, 1'b1, 8'hF2, 1'b0);
        send("R8", 8'h10, 2'b00, 1'b1, 8'h3F, 1'b1);
        write_fmt(1'b1, 1'b0);
        check("R9", "flat write while enabled ignored", fmt_cluster, 1'b1);
        write_fmt(1'b0, 1'b0);
        check("R9", "flat write while disabled taken", fmt_cluster, 1'b0);
    endtask

    task automatic t_pulse;
        @(negedge clk);
        msg_valid = 1'b1; msg_shorthand = 2'b10;
        @(negedge clk);
        check("R10", "first of back-to-back", accept, 1'b1);
        @(negedge clk);
        check("R10", "second of back-to-back", accept, 1'b1);
        msg_valid = 1'b0;
        @(negedge clk);
        check("R10", "low after last valid", accept, 1'b0);
        msg_shorthand = 2'b10;
        @(negedge clk);
        check("R10", "no accept without valid", accept, 1'b0);
        msg_shorthand = 2'b00;
    endtask

    initial begin
        t_reset();
        t_shorthand();
        t_ignore_fields();
        t_physical();
        t_flat();
        t_format_lock();
        t_cluster();
        t_pulse();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                failures++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule